// File: doc/BRIEF.md
# Machine-Cycle Rate Control with Automatic Switchback

This block decides how many oscillator cycles make one machine cycle and emits a one-cycle enable strobe at that rate for the rest of the core. A 2-bit rate code and a switchback enable are loaded by a register write. Code `11` selects the low-power rate of one strobe per `SLOW_DIV` (1024 by default) oscillator cycles. Code `10` is the full-speed rate of one strobe per oscillator cycle, and it is the value after reset.

With the low-power rate active and switchback enabled, the block returns to full speed by itself on any of three kinds of event: a qualified external interrupt level, a falling edge on an enabled serial receive pin, or serial transmit activity. A request to enter the low-power rate is refused while any serial port is transferring, and the code is then set to `10`. The interrupt controller and the serial ports sit outside the block. They supply the enable, priority-allow and busy qualifiers.

Top module: `mcycle_rate_ctrl`

## Requirements
- R1: After reset `div_code` is `10`, switchback is disabled, and `mc_stb` is high in every cycle.
- R2: A write (`reg_wr`=1) loads `wr_div_code` into `div_code` at the next edge and loads `wr_swb_en` as the switchback enable. The code only becomes `11` through such a write.
- R3: On the first cycle that shows a new `div_code`, `mc_stb` is low. The first strobe comes one full new period later: `SLOW_DIV` cycles later for code `11`, and 1 cycle later for any other code. Under code `11`, strobes are then spaced exactly `SLOW_DIV` cycles apart.
- R4: While switchback is disabled, interrupt and serial events never change `div_code`.
- R5: With code `11` and switchback enabled, a qualified interrupt sets `div_code` to `10` at the next edge. A line is qualified when its enable and allow bits are both 1 and it is at its active level. Lines 0, 1, 3 and 5 are active low. Lines 2 and 4 are active high.
- R6: With code `11` and switchback enabled, a falling edge on `rx_pin[i]` while `rx_en[i]`=1 sets `div_code` to `10`. This happens at the third edge after the pin falls: two synchronizer stages, then edge detection. It works regardless of any serial interrupt setting. With `rx_en[i]`=0 the edge has no effect.
- R7: With code `11` and switchback enabled, any `tx_busy` bit set sets `div_code` to `10` at the next edge.
- R8: A write of code `11` while any `tx_busy` or `rx_busy` bit is 1 loads `10` instead.
- R9: Under codes `00`, `01` and `10`, switchback events are ignored, and `mc_stb` is high every cycle except the cycle a new code first appears.
- R10: A write and a switchback event in the same cycle resolve in favour of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Rate register write strobe |
| wr_div_code | input | 2 | Rate code written (11 slow, 10 full speed) |
| wr_swb_en | input | 1 | Switchback enable written |
| irq_pin | input | NIRQ | External interrupt pin levels |
| irq_en | input | NIRQ | Per-line interrupt enable |
| irq_allow | input | NIRQ | Per-line allow from the nesting priority logic |
| rx_pin | input | NPORT | Serial receive pins, asynchronous, idle high |
| rx_en | input | NPORT | Per-port receive enable |
| tx_busy | input | NPORT | Per-port transmit in progress |
| rx_busy | input | NPORT | Per-port receive in progress |
| mc_stb | output | 1 | Machine-cycle enable strobe |
| div_code | output | 2 | Current rate code |

## Verification
A wrong rate register shows on `div_code` one edge after the write or event that caused it. The one exception is a receive edge, which shows three edges after the pin moves. A fault in the strobe counter or its reload stays hidden at full speed, because the strobe is high every cycle there. Under code `11` it moves the first strobe away from exactly `SLOW_DIV` cycles after the change, so it is exposed within one slow period. A mis-wired level polarity or qualifier shows as a missed or spurious return to code `10` on the very next edge.

// File: rtl/mcycle_rate_pkg.sv
package mcycle_rate_pkg;

  localparam logic [1:0] RATE_CODE_FAST = 2'b10;
  localparam logic [1:0] RATE_CODE_SLOW = 2'b11;

  // Oscillator cycles per machine cycle for a rate code.
  function automatic int unsigned cycles_per_strobe(input logic [1:0] code,
                                                    input int unsigned slow_div);
    return (code == RATE_CODE_SLOW) ? slow_div : 1;
  endfunction

  // True when an interrupt pin sits at its active level.
  function automatic logic irq_level_active(input logic pin, input logic high_active);
    return high_active ? pin : ~pin;
  endfunction

endpackage

// File: rtl/mcycle_rx_edge.sv
module mcycle_rx_edge #(
  parameter int unsigned NPORT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] rx_pin,
  output logic [NPORT-1:0] rx_fall
);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        last_q <= 1'b1;
      end else begin
        meta_q <= rx_pin[p];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign rx_fall[p] = last_q & ~sync_q;
  end

endmodule

// File: rtl/mcycle_sb_qual.sv
module mcycle_sb_qual
  import mcycle_rate_pkg::*;
#(
  parameter int unsigned       NIRQ          = 6,
  parameter int unsigned       NPORT         = 2,
  parameter logic [NIRQ-1:0]   IRQ_HIGH_MASK = 6'b010100
) (
  input  logic [NIRQ-1:0]  irq_pin,
  input  logic [NIRQ-1:0]  irq_en,
  input  logic [NIRQ-1:0]  irq_allow,
  input  logic [NPORT-1:0] rx_fall,
  input  logic [NPORT-1:0] rx_en,
  input  logic [NPORT-1:0] tx_busy,
  output logic             irq_hit,
  output logic             rx_hit,
  output logic             tx_hit,
  output logic             sb_event
);

  logic [NIRQ-1:0]  line_hit;
  logic [NPORT-1:0] port_rx_hit;

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign line_hit[i] = irq_en[i] & irq_allow[i]
                       & irq_level_active(irq_pin[i], IRQ_HIGH_MASK[i]);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rx
    assign port_rx_hit[p] = rx_en[p] & rx_fall[p];
  end

  assign irq_hit  = |line_hit;
  assign rx_hit   = |port_rx_hit;
  assign tx_hit   = |tx_busy;
  assign sb_event = irq_hit | rx_hit | tx_hit;

endmodule

// File: rtl/mcycle_strobe_gen.sv
module mcycle_strobe_gen
  import mcycle_rate_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output logic       stb
);

  localparam int unsigned CNT_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic [1:0]       code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_val;
  logic             code_moved;

  assign code_moved = (code != code_q);
  assign reload_val = CNT_W'(cycles_per_strobe(code, SLOW_DIV) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= RATE_CODE_FAST;
      cnt_q  <= '0;
    end else begin
      code_q <= code;
      if (code_moved || cnt_q == '0) cnt_q <= reload_val;
      else                           cnt_q <= cnt_q - 1'b1;
    end
  end

  assign stb = !code_moved && (cnt_q == '0);

endmodule

// File: rtl/mcycle_rate_ctrl.sv
module mcycle_rate_ctrl
  import mcycle_rate_pkg::*;
#(
  parameter int unsigned     NIRQ          = 6,
  parameter int unsigned     NPORT         = 2,
  parameter int unsigned     SLOW_DIV      = 1024,
  parameter logic [NIRQ-1:0] IRQ_HIGH_MASK = 6'b010100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       wr_div_code,
  input  logic             wr_swb_en,
  input  logic [NIRQ-1:0]  irq_pin,
  input  logic [NIRQ-1:0]  irq_en,
  input  logic [NIRQ-1:0]  irq_allow,
  input  logic [NPORT-1:0] rx_pin,
  input  logic [NPORT-1:0] rx_en,
  input  logic [NPORT-1:0] tx_busy,
  input  logic [NPORT-1:0] rx_busy,
  output logic             mc_stb,
  output logic [1:0]       div_code
);

  logic [1:0]       div_q;
  logic             swb_q;
  logic [NPORT-1:0] rx_fall;
  logic             irq_hit, rx_hit, tx_hit, sb_event;
  logic             xfer_active;
  logic             entry_blocked;
  logic             sb_fire;
  logic [1:0]       wr_code_eff;

  mcycle_rx_edge #(.NPORT(NPORT)) u_rx_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_pin  (rx_pin),
    .rx_fall (rx_fall)
  );

  mcycle_sb_qual #(
    .NIRQ          (NIRQ),
    .NPORT         (NPORT),
    .IRQ_HIGH_MASK (IRQ_HIGH_MASK)
  ) u_sb_qual (
    .irq_pin   (irq_pin),
    .irq_en    (irq_en),
    .irq_allow (irq_allow),
    .rx_fall   (rx_fall),
    .rx_en     (rx_en),
    .tx_busy   (tx_busy),
    .irq_hit   (irq_hit),
    .rx_hit    (rx_hit),
    .tx_hit    (tx_hit),
    .sb_event  (sb_event)
  );

  assign xfer_active   = (|tx_busy) | (|rx_busy);
  assign entry_blocked = (wr_div_code == RATE_CODE_SLOW) && xfer_active;
  assign wr_code_eff   = entry_blocked ? RATE_CODE_FAST : wr_div_code;
  assign sb_fire       = (div_q == RATE_CODE_SLOW) && swb_q && sb_event;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= RATE_CODE_FAST;
      swb_q <= 1'b0;
    end else if (reg_wr) begin
      div_q <= wr_code_eff;
      swb_q <= wr_swb_en;
    end else if (sb_fire) begin
      div_q <= RATE_CODE_FAST;
    end
  end

  mcycle_strobe_gen #(.SLOW_DIV(SLOW_DIV)) u_strobe (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (div_q),
    .stb   (mc_stb)
  );

  assign div_code = div_q;

endmodule

// File: rtl/mcycle_rate_chk.sv
module mcycle_rate_chk #(
  parameter int unsigned NPORT    = 2,
  parameter int unsigned SLOW_DIV = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [NPORT-1:0] tx_busy,
  input logic [NPORT-1:0] rx_busy,
  input logic [1:0]       wr_div_code,
  input logic [1:0]       div_code,
  input logic             mc_stb,
  input logic             swb_q,
  input logic             sb_event,
  input logic             irq_hit,
  input logic             rx_hit,
  input logic             tx_hit
);

  logic [1:0]  prev_div;
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_div <= 2'b10;
      gap      <= 0;
    end else begin
      prev_div <= div_code;
      if (div_code != prev_div || mc_stb) gap <= 0;
      else                                gap <= gap + 1;
    end
  end

  assert_fast_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code != 2'b11 && div_code == prev_div) |-> mc_stb);

  assert_slow_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == 2'b11 && mc_stb) |-> (gap == SLOW_DIV - 1));

  assert_slow_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == 2'b11 && prev_div != 2'b11) |-> $past(reg_wr));

  assert_entry_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wr_div_code == 2'b11 && ((|tx_busy) || (|rx_busy))) |=> div_code == 2'b10);

  assert_swb_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!swb_q && !reg_wr) |=> $stable(div_code));

  assert_irq_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == 2'b11 && swb_q && irq_hit && !reg_wr) |=> div_code == 2'b10);

  assert_rx_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == 2'b11 && swb_q && rx_hit && !reg_wr) |=> div_code == 2'b10);

  assert_tx_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code == 2'b11 && swb_q && tx_hit && !reg_wr) |=> div_code == 2'b10);

  assert_other_codes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code != 2'b11 && sb_event && !reg_wr) |=> $stable(div_code));

endmodule

bind mcycle_rate_ctrl mcycle_rate_chk #(.NPORT(NPORT), .SLOW_DIV(SLOW_DIV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .tx_busy     (tx_busy),
  .rx_busy     (rx_busy),
  .wr_div_code (wr_div_code),
  .div_code    (div_code),
  .mc_stb      (mc_stb),
  .swb_q       (swb_q),
  .sb_event    (sb_event),
  .irq_hit     (irq_hit),
  .rx_hit      (rx_hit),
  .tx_hit      (tx_hit)
);

// File: tb/mcycle_rate_ctrl_bench.sv
`timescale 1ns/1ps
module mcycle_rate_ctrl_bench;

  localparam int NIRQ     = 6;
  localparam int NPORT    = 2;
  localparam int SLOW_DIV = 1024;
  localparam logic [NIRQ-1:0] IRQ_IDLE = 6'b101011;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             reg_wr;
  logic [1:0]       wr_div_code;
  logic             wr_swb_en;
  logic [NIRQ-1:0]  irq_pin, irq_en, irq_allow;
  logic [NPORT-1:0] rx_pin, rx_en, tx_busy, rx_busy;
  logic             mc_stb;
  logic [1:0]       div_code;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mcycle_rate_ctrl #(.NIRQ(NIRQ), .NPORT(NPORT), .SLOW_DIV(SLOW_DIV)) u_mcycle_rate_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .wr_div_code (wr_div_code),
    .wr_swb_en   (wr_swb_en),
    .irq_pin     (irq_pin),
    .irq_en      (irq_en),
    .irq_allow   (irq_allow),
    .rx_pin      (rx_pin),
    .rx_en       (rx_en),
    .tx_busy     (tx_busy),
    .rx_busy     (rx_busy),
    .mc_stb      (mc_stb),
    .div_code    (div_code)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] code, input logic swb);
    reg_wr = 1'b1; wr_div_code = code; wr_swb_en = swb;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic quiet_inputs();
    irq_pin = IRQ_IDLE; irq_en = '1; irq_allow = '1;
    rx_pin = '1; rx_en = '0; tx_busy = '0; rx_busy = '0;
  endtask

  // Count cycles until mc_stb is seen high.
  task automatic cycles_to_strobe(output int n);
    n = 0;
    for (int i = 0; i < 3 * SLOW_DIV; i++) begin
      tick();
      n++;
      if (mc_stb) break;
    end
  endtask

  task automatic t_reset();
    check("R1 reset div_code", div_code, 2);
    for (int i = 0; i < 4; i++) begin
      check("R1 strobe every cycle after reset", mc_stb, 1);
      tick();
    end
    irq_pin[0] = 1'b0; // switchback disabled after reset, code stays 10
    tick(2);
    check("R1 no change with switchback off", div_code, 2);
    irq_pin = IRQ_IDLE;
  endtask

  task automatic t_slow_period();
    int n;
    wr(2'b11, 1'b0);
    check("R2 write loads slow code", div_code, 3);
    check("R3 strobe low on change cycle", mc_stb, 0);
    cycles_to_strobe(n);
    check("R3 first slow strobe distance", n, SLOW_DIV);
    cycles_to_strobe(n);
    check("R3 slow strobe spacing", n, SLOW_DIV);
    wr(2'b10, 1'b0);
    check("R2 write loads fast code", div_code, 2);
    check("R3 strobe low on return cycle", mc_stb, 0);
    tick();
    check("R3 fast strobe one cycle later", mc_stb, 1);
  endtask

  task automatic t_swb_off();
    wr(2'b11, 1'b0);
    irq_pin[0] = 1'b0; tx_busy[0] = 1'b1; rx_en = '1; rx_pin[1] = 1'b0;
    tick(5);
    check("R4 events ignored with switchback off", div_code, 3);
    quiet_inputs();
    tick(4);
    wr(2'b10, 1'b0);
  endtask

  task automatic t_irq();
    wr(2'b11, 1'b1);
    irq_pin[3] = 1'b0;
    tick();
    check("R5 line 3 low returns to fast", div_code, 2);
    irq_pin = IRQ_IDLE;
    wr(2'b11, 1'b1);
    irq_pin[4] = 1'b1;
    tick();
    check("R5 line 4 high returns to fast", div_code, 2);
    irq_pin = IRQ_IDLE;
    wr(2'b11, 1'b1);
    tick(3);
    check("R5 idle levels do not qualify", div_code, 3);
    irq_en[0] = 1'b0; irq_pin[0] = 1'b0;
    tick(3);
    check("R5 disabled line ignored", div_code, 3);
    irq_allow[1] = 1'b0; irq_pin[1] = 1'b0;
    tick(3);
    check("R5 line not allowed ignored", div_code, 3);
    quiet_inputs();
    wr(2'b10, 1'b0);
  endtask

  task automatic t_rx();
    rx_en[0] = 1'b1;
    wr(2'b11, 1'b1);
    rx_pin[0] = 1'b0;
    tick(2);
    check("R6 no return before sync delay", div_code, 3);
    tick();
    check("R6 return three edges after fall", div_code, 2);
    rx_pin[0] = 1'b1;
    tick(4);
    wr(2'b11, 1'b1);
    rx_pin[1] = 1'b0; // port 1 receive disabled
    tick(5);
    check("R6 disabled port edge ignored", div_code, 3);
    quiet_inputs();
    tick(4);
    wr(2'b10, 1'b0);
  endtask

  task automatic t_tx();
    wr(2'b11, 1'b1);
    tx_busy[1] = 1'b1;
    tick();
    check("R7 transmit returns to fast", div_code, 2);
    tx_busy = '0;
  endtask

  task automatic t_entry_blocked();
    tx_busy[0] = 1'b1;
    wr(2'b11, 1'b0);
    check("R8 slow refused while transmitting", div_code, 2);
    tx_busy = '0;
    rx_busy[1] = 1'b1;
    wr(2'b11, 1'b0);
    check("R8 slow refused while receiving", div_code, 2);
    rx_busy = '0;
    wr(2'b11, 1'b0);
    check("R8 slow accepted when idle", div_code, 3);
    wr(2'b10, 1'b0);
  endtask

  task automatic t_other_codes();
    wr(2'b01, 1'b1);
    check("R9 code 01 loaded", div_code, 1);
    irq_pin[0] = 1'b0; tx_busy[0] = 1'b1;
    tick();
    check("R9 strobe under code 01", mc_stb, 1);
    tick(3);
    check("R9 code 01 ignores events", div_code, 1);
    check("R9 strobe stays high", mc_stb, 1);
    quiet_inputs();
    wr(2'b00, 1'b1);
    irq_pin[4] = 1'b1;
    tick(3);
    check("R9 code 00 ignores events", div_code, 0);
    quiet_inputs();
    wr(2'b10, 1'b0);
  endtask

  task automatic t_write_wins();
    wr(2'b11, 1'b1);
    irq_pin[0] = 1'b0;
    reg_wr = 1'b1; wr_div_code = 2'b11; wr_swb_en = 1'b0;
    tick();
    reg_wr = 1'b0;
    check("R10 write wins over same-cycle event", div_code, 3);
    tick(3);
    check("R10 switchback now off, code held", div_code, 3);
    quiet_inputs();
    wr(2'b10, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; wr_div_code = 2'b10; wr_swb_en = 1'b0;
    quiet_inputs();
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_slow_period();
    t_swb_off();
    t_irq();
    t_rx();
    t_tx();
    t_entry_blocked();
    t_other_codes();
    t_write_wins();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule